// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This unit sits on the path from a processor core to memory. It turns each logical address that a process issues into a physical address. A user-mode access is checked against a limit register. The check is a strict less-than comparison. When the access passes, the unit adds a base register to the logical address and presents the sum to memory as a valid request. When the access fails, no memory request is made. Instead the unit raises a one-cycle fault pulse and records the offending logical address, so that software handling the interrupt can inspect it.

Supervisor-mode accesses skip the limit comparison. They are still relocated by the base register, so the kernel reaches any region of physical memory by programming the base. Only a supervisor may load the base and limit registers, through a small write port. A user-mode write leaves both registers untouched and raises the fault output. After reset the limit is zero, so every user access faults until the kernel sets up a region. Requests and configuration writes are sampled on a clock edge, and every result appears on the registered outputs one cycle later.

Top module: `reloc_unit`

## Requirements
- R1: After reset, `mem_valid`, `fault`, `fault_cause` and `fault_addr` are all zero. The limit resets to 0 and the base resets to 0, so any user-mode access made before programming faults.
- R2: A user-mode request (`req_priv`=0) whose address is strictly less than the limit produces `mem_valid`=1 one cycle later. In that cycle `mem_addr` equals the address plus the base, modulo 2^PA_W, and `fault` stays 0.
- R3: A user-mode request whose address is greater than or equal to the limit produces `mem_valid`=0 one cycle later. In that same cycle `fault`=1, `fault_cause[0]`=1 and `fault_addr` equals the rejected address.
- R4: A supervisor request (`req_priv`=1) always produces `mem_valid`=1 one cycle later, with `mem_addr` equal to the address plus the base, whatever the limit holds.
- R5: A supervisor write (`cfg_we`=1, `cfg_priv`=1) updates a register. `cfg_sel`=0 selects the base, which takes `cfg_data`. `cfg_sel`=1 selects the limit, which takes `cfg_data[LA_W:0]`. A request in the same cycle as the write still uses the old register values, and requests from the next cycle onward use the new ones.
- R6: A user-mode write (`cfg_we`=1, `cfg_priv`=0) changes neither register. One cycle later it produces `fault`=1 with `fault_cause[1]`=1.
- R7: In a cycle with no request and no write, the following cycle shows `mem_valid`=0 and `fault`=0. Each fault is therefore a single-cycle pulse.
- R8: `fault_addr` changes only on a limit violation, and otherwise holds the last rejected address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | LA_W | Logical address |
| req_priv | input | 1 | 1 = supervisor, 0 = user |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Privilege of the writer, 1 = supervisor |
| cfg_sel | input | 1 | 0 = base, 1 = limit |
| cfg_data | input | PA_W | Write data |
| mem_valid | output | 1 | Translated request to memory |
| mem_addr | output | PA_W | Physical address |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 2 | bit0 limit violation, bit1 user write attempt |
| fault_addr | output | LA_W | Last logical address rejected by the limit |

## Verification
Every request and every write is sampled on one rising edge. Its translation, fault pulse and captured address all appear on the outputs right after the following rising edge. The bench drives stimulus on the falling edge. It waits for exactly one rising edge and samples one time unit later, before it drives the next stimulus. A register write therefore affects only requests sampled at a later edge, and the same-cycle case is checked by issuing a request together with a write. The absence of a fault and the hold of `fault_addr` are checked on the cycle directly after an idle or accepted cycle.

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int LA_W = 8,
  parameter int PA_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [LA_W-1:0] req_addr,
  input  logic            req_priv,
  input  logic            cfg_we,
  input  logic            cfg_priv,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_data,
  output logic            mem_valid,
  output logic [PA_W-1:0] mem_addr,
  output logic            fault,
  output logic [1:0]      fault_cause,
  output logic [LA_W-1:0] fault_addr
);
  localparam int LIM_W = LA_W + 1;
  localparam int PAD_W = PA_W - LA_W;

  logic [PA_W-1:0]  base_q;
  logic [LIM_W-1:0] limit_q;

  wire in_bound  = {1'b0, req_addr} < limit_q;
  wire grant     = req_valid && (req_priv || in_bound);
  wire bound_err = req_valid && !req_priv && !in_bound;
  wire wr_ok     = cfg_we && cfg_priv;
  wire wr_err    = cfg_we && !cfg_priv;
  wire [PA_W-1:0] phys = {{PAD_W{1'b0}}, req_addr} + base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_ok) begin
      if (cfg_sel) limit_q <= cfg_data[LIM_W-1:0];
      else         base_q  <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      fault       <= 1'b0;
      fault_cause <= '0;
      fault_addr  <= '0;
    end else begin
      mem_valid   <= grant;
      if (grant) mem_addr <= phys;
      fault       <= bound_err || wr_err;
      fault_cause <= {wr_err, bound_err};
      if (bound_err) fault_addr <= req_addr;
    end
  end
endmodule

module reloc_unit_chk #(
  parameter int LA_W = 8,
  parameter int PA_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [LA_W-1:0] req_addr,
  input logic            req_priv,
  input logic            cfg_we,
  input logic            cfg_priv,
  input logic            mem_valid,
  input logic            fault,
  input logic [1:0]      fault_cause,
  input logic [LA_W-1:0] fault_addr,
  input logic [PA_W-1:0] base_q,
  input logic [LA_W:0]   limit_q
);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && ({1'b0, req_addr} < limit_q)) |=> (mem_valid && !fault_cause[0]));

  a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && ({1'b0, req_addr} >= limit_q))
      |=> (!mem_valid && fault && fault_cause[0] && fault_addr == $past(req_addr)));

  a_r4_supervisor: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv) |=> mem_valid);

  a_r6_user_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> (fault && fault_cause[1] && $stable(base_q) && $stable(limit_q)));

  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !cfg_we) |=> (!mem_valid && !fault));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_priv && ({1'b0, req_addr} >= limit_q)) |=> $stable(fault_addr));
endmodule

bind reloc_unit reloc_unit_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_priv(req_priv), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
  .mem_valid(mem_valid), .fault(fault), .fault_cause(fault_cause),
  .fault_addr(fault_addr), .base_q(base_q), .limit_q(limit_q)
);

// File: tb/sim_reloc_unit.sv
`timescale 1ns/1ps
module sim_reloc_unit;
  localparam int LA_W = 8;
  localparam int PA_W = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_priv = 0, cfg_we = 0, cfg_priv = 0, cfg_sel = 0;
  logic [LA_W-1:0] req_addr = '0;
  logic [PA_W-1:0] cfg_data = '0;
  logic mem_valid, fault;
  logic [PA_W-1:0] mem_addr;
  logic [1:0] fault_cause;
  logic [LA_W-1:0] fault_addr;

  int errors = 0, checks = 0;
  int cur_base = 0, cur_limit = 0, last_fault = 0;

  always #5 clk = ~clk;

  reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_priv(req_priv), .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .fault(fault), .fault_cause(fault_cause), .fault_addr(fault_addr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 0; cfg_priv = 0;
  endtask

  task automatic wr(input int sel, input int val, input int priv);
    @(negedge clk);
    cfg_we = 1; cfg_priv = priv[0]; cfg_sel = sel[0]; cfg_data = val[PA_W-1:0];
    step();
    if (priv != 0) begin
      if (sel != 0) cur_limit = val % (1 << (LA_W + 1)); else cur_base = val;
    end
  endtask

  task automatic access(input int a, input int priv);
    bit ok;
    @(negedge clk);
    req_valid = 1; req_addr = a[LA_W-1:0]; req_priv = priv[0];
    step();
    ok = (priv != 0) || (a < cur_limit);
    if (priv != 0) chk("R4 valid", int'(mem_valid), 1);
    else chk(ok ? "R2 valid" : "R3 valid", int'(mem_valid), ok ? 1 : 0);
    if (ok) chk(priv != 0 ? "R4 addr" : "R2 addr", int'(mem_addr), (a + cur_base) % (1 << PA_W));
    chk(ok ? "R2 nofault" : "R3 fault", int'(fault), ok ? 0 : 1);
    if (!ok) begin
      chk("R3 cause", int'(fault_cause), 1);
      last_fault = a;
    end
    chk(ok ? "R8 hold" : "R3 addr", int'(fault_addr), last_fault);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bases[4] = '{0, 37, 1000, 1023};
    int lims[4]  = '{1, 128, 255, 256};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 mem_valid", int'(mem_valid), 0);
    chk("R1 fault", int'(fault), 0);
    chk("R1 fault_addr", int'(fault_addr), 0);
    access(0, 0);
    access(200, 0);
    access(5, 1);
    for (int k = 0; k < 4; k++) begin
      wr(0, bases[k], 1);
      wr(1, lims[k], 1);
      for (int a = 0; a < (1 << LA_W); a++) access(a, 0);
      for (int a = 0; a < (1 << LA_W); a += 17) access(a, 1);
    end
    wr(0, 100, 1);
    wr(1, 50, 1);
    wr(1, 0, 0);
    chk("R6 fault", int'(fault), 1);
    chk("R6 cause", int'(fault_cause), 2);
    wr(0, 7, 0);
    chk("R6 fault", int'(fault), 1);
    access(49, 0);
    access(50, 0);
    step();
    chk("R7 idle valid", int'(mem_valid), 0);
    chk("R7 pulse", int'(fault), 0);
    chk("R8 hold idle", int'(fault_addr), 50);
    @(negedge clk);
    cfg_we = 1; cfg_priv = 1; cfg_sel = 1; cfg_data = 0;
    req_valid = 1; req_addr = 10; req_priv = 0;
    step();
    chk("R5 same-cycle old limit", int'(mem_valid), 1);
    chk("R5 same-cycle addr", int'(mem_addr), 110);
    cur_limit = 0;
    access(10, 0);
    wr(0, 3, 1);
    access(4, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule